// File: doc/BRIEF.md
# Linked-Descriptor Buffer Mover

This block moves data between system memory and a word-wide data FIFO under the control of descriptors kept in memory. Each descriptor occupies four consecutive 32-bit words: the word at offset 0 carries control flags, offset 4 holds the buffer length in bytes, offset 8 holds the buffer start address, and offset 12 may hold the address of the following descriptor. Software builds a chain of descriptors, hands each one to the engine by setting its ownership flag, and strobes a poll input. The engine reads each descriptor, moves its buffer one 32-bit word at a time, writes the control word back with the ownership flag cleared, and follows the chain. A descriptor it does not own makes it stop and report that no descriptor was available.

The direction input picks transmit (memory to FIFO) or receive (FIFO to memory) and is sampled when a poll starts the engine. Four sticky status bits record transmit completion, receive completion, a normal-interrupt summary, and the descriptor-unavailable condition. A matching clear vector removes them, one bit per 1. A soft-reset strobe returns the engine and its status to the after-reset state.

The controller is a single state machine with these states: IDLE (waiting for a poll), FETCH (reading the four descriptor words), MEM_RD and FIFO_PUSH (transmit beat: read one word, then push it), FIFO_POP and MEM_WR (receive beat: pop one word, then write it), and WBACK (returning the control word). The transitions are: IDLE→FETCH on poll while enabled. FETCH→IDLE when the first word shows the descriptor is not owned. FETCH→WBACK for a zero-length buffer. FETCH→MEM_RD or FETCH→FIFO_POP otherwise. MEM_RD→FIFO_PUSH on memory acknowledge. FIFO_PUSH→MEM_RD or FIFO_PUSH→WBACK after a push. FIFO_POP→MEM_WR after a pop. MEM_WR→FIFO_POP or MEM_WR→WBACK on acknowledge. WBACK→FETCH, or WBACK→IDLE when the descriptor is marked last. A soft reset sends every state to IDLE.

Top module: `chain_dma`

## Requirements
- R1: After power-on reset or a one-cycle `soft_rst` pulse, `busy` and `irq` are 0, `sts` is 0, and the next accepted poll fetches its first descriptor from `base_addr`.
- R2: A one-cycle `poll` while idle and `enable`=1 starts fetching at the current descriptor address. That address is `base_addr` for the first poll after a reset; afterwards it is wherever the previous run left off. A poll with `enable`=0 has no effect.
- R3: If the control word (offset 0) has bit 31 (ownership) equal to 0, the engine moves no data, sets `sts[3]` (descriptor unavailable), and returns to idle. The next poll re-reads the same descriptor address.
- R4: Bits [11:0] of the length word (offset 4) give the byte count. The engine moves ceil(count/4) 32-bit words, and a count of 0 moves none.
- R5: In transmit (`dir_tx`=1), words read from the buffer address upward in steps of 4 are pushed into the FIFO in address order.
- R6: In receive (`dir_tx`=0), words popped from the FIFO are written to the buffer address upward in steps of 4, in pop order.
- R7: After the buffer, the control word is written back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R8: The next descriptor address is `base_addr` if control bit 5 (end of ring) is set. Otherwise it is the word at offset 12 if control bit 4 (chained) is set. Otherwise it is the descriptor address plus 16.
- R9: After writing back a descriptor with control bit 2 (last) set, the engine stops with `busy`=0. Without that bit it fetches the next descriptor.
- R10: Completing a descriptor whose control bit 1 (interrupt suppress) is 0 sets `sts[0]` (transmit done) or `sts[1]` (receive done), together with `sts[2]` (summary). With bit 1 set, no status changes. `irq` = `sts[2]` | `sts[3]`.
- R11: Each 1 in `sts_clr` clears the matching `sts` bit one cycle later. Bits not selected are kept, and a new event wins over a clear in the same cycle.
- R12: The engine never pushes while `fifo_full` is 1 and never pops while `fifo_empty` is 1. It waits instead.
- R13: Once raised, `mem_req`, `mem_we` and `mem_addr` stay unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_rst | input | 1 | One-cycle engine and status reset |
| enable | input | 1 | Allows a poll to start the engine |
| poll | input | 1 | One-cycle start/resume strobe |
| dir_tx | input | 1 | 1 = memory to FIFO, 0 = FIFO to memory |
| base_addr | input | AW | Address of the first descriptor |
| sts_clr | input | 4 | Write-1-to-clear strobes for `sts` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| fifo_push | output | 1 | Push one word into the FIFO |
| fifo_wdata | output | 32 | Word pushed |
| fifo_full | input | 1 | FIFO cannot accept |
| fifo_pop | output | 1 | Take the head word from the FIFO |
| fifo_rdata | input | 32 | Head word of the FIFO |
| fifo_empty | input | 1 | FIFO has no word |
| busy | output | 1 | Engine is not idle |
| sts | output | 4 | [0] tx done, [1] rx done, [2] summary, [3] descriptor unavailable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults, AW=32 and a 12-bit length field, so buffer counts that are not a multiple of four can be reached. A 2 KiB memory model lets a chained jump, a contiguous step and an end-of-ring wrap all occur in one run. Memory acknowledges and FIFO full/empty flags stall on a fixed rhythm, so every wait state of the transmit and receive beats is entered. The unowned-descriptor stop, its resume on the same address, a zero-length buffer, interrupt suppression, a poll while disabled and a soft reset that re-selects the base address are each driven in turn.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_MEM_RD,
        S_FIFO_PUSH,
        S_FIFO_POP,
        S_MEM_WR,
        S_WBACK
    } dma_state_e;

    // control word flag positions (decoded by software and engine alike)
    localparam int OWN_BIT   = 31;
    localparam int EOR_BIT   = 5;
    localparam int CHAIN_BIT = 4;
    localparam int LAST_BIT  = 2;
    localparam int NOIRQ_BIT = 1;

    localparam int WORD_BYTES = 4;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES = WORD_BYTES * DESC_WORDS;

    // status vector layout
    localparam int ST_TX   = 0;
    localparam int ST_RX   = 1;
    localparam int ST_SUM  = 2;
    localparam int ST_UNAV = 3;
    localparam int ST_W    = 4;

endpackage

// File: rtl/chain_dma_core.sv
module chain_dma_core
    import chain_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          enable,
    input  logic          poll,
    input  logic          dir_tx,
    input  logic [AW-1:0] base_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          fifo_push,
    output logic [31:0]   fifo_wdata,
    input  logic          fifo_full,
    output logic          fifo_pop,
    input  logic [31:0]   fifo_rdata,
    input  logic          fifo_empty,
    output logic          busy,
    output logic          evt_done,
    output logic          evt_tx,
    output logic          evt_unavail
);

    localparam int WCNT_W = $clog2(DESC_WORDS);
    localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(DESC_WORDS - 1);
    localparam logic [LEN_W-1:0]  BEAT      = LEN_W'(WORD_BYTES);

    dma_state_e        state_q, state_d;
    logic [WCNT_W-1:0] wcnt_q;
    logic [AW-1:0]     cur_q, buf_q, nxt_q;
    logic [31:0]       ctrl_q, data_q;
    logic [LEN_W-1:0]  rem_q;
    logic              dir_q, started_q;
    logic              start, last_beat, owned;

    assign start     = (state_q == S_IDLE) && poll && enable;
    assign last_beat = (rem_q <= BEAT);
    assign owned     = mem_rdata[OWN_BIT];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = cur_q;
        mem_wdata   = data_q;
        fifo_push   = 1'b0;
        fifo_pop    = 1'b0;
        fifo_wdata  = data_q;
        evt_done    = 1'b0;
        evt_unavail = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_FETCH;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'({wcnt_q, 2'b00});
                if (mem_ack) begin
                    if (wcnt_q == '0 && !owned) begin
                        evt_unavail = 1'b1;
                        state_d     = S_IDLE;
                    end else if (wcnt_q == WCNT_LAST) begin
                        if (rem_q == '0)  state_d = S_WBACK;
                        else if (dir_q)   state_d = S_MEM_RD;
                        else              state_d = S_FIFO_POP;
                    end
                end
            end
            S_MEM_RD: begin
                mem_req  = 1'b1;
                mem_addr = buf_q;
                if (mem_ack) state_d = S_FIFO_PUSH;
            end
            S_FIFO_PUSH: begin
                if (!fifo_full) begin
                    fifo_push = 1'b1;
                    state_d   = last_beat ? S_WBACK : S_MEM_RD;
                end
            end
            S_FIFO_POP: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    state_d  = S_MEM_WR;
                end
            end
            S_MEM_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = buf_q;
                if (mem_ack) state_d = last_beat ? S_WBACK : S_FIFO_POP;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = {1'b0, ctrl_q[OWN_BIT-1:0]};
                if (mem_ack) begin
                    evt_done = !ctrl_q[NOIRQ_BIT];
                    state_d  = ctrl_q[LAST_BIT] ? S_IDLE : S_FETCH;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (soft_rst) begin
            state_d     = S_IDLE;
            evt_done    = 1'b0;
            evt_unavail = 1'b0;
        end
    end

    assign busy   = (state_q != S_IDLE);
    assign evt_tx = dir_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            wcnt_q    <= '0;
            cur_q     <= '0;
            buf_q     <= '0;
            nxt_q     <= '0;
            ctrl_q    <= '0;
            data_q    <= '0;
            rem_q     <= '0;
            dir_q     <= 1'b0;
            started_q <= 1'b0;
        end else begin
            if (start) begin
                started_q <= 1'b1;
                dir_q     <= dir_tx;
                wcnt_q    <= '0;
                if (!started_q) cur_q <= base_addr;
            end
            if (state_q == S_FETCH && mem_ack) begin
                wcnt_q <= wcnt_q + 1'b1;
                unique case (wcnt_q)
                    2'd0:    ctrl_q <= mem_rdata;
                    2'd1:    rem_q  <= mem_rdata[LEN_W-1:0];
                    2'd2:    buf_q  <= mem_rdata[AW-1:0];
                    default: nxt_q  <= mem_rdata[AW-1:0];
                endcase
            end
            if (state_q == S_MEM_RD && mem_ack) data_q <= mem_rdata;
            if (state_q == S_FIFO_POP && !fifo_empty) data_q <= fifo_rdata;
            if ((state_q == S_FIFO_PUSH && !fifo_full) ||
                (state_q == S_MEM_WR && mem_ack)) begin
                buf_q <= buf_q + AW'(WORD_BYTES);
                rem_q <= last_beat ? '0 : rem_q - BEAT;
            end
            if (state_q == S_WBACK && mem_ack) begin
                wcnt_q <= '0;
                if (ctrl_q[EOR_BIT])        cur_q <= base_addr;
                else if (ctrl_q[CHAIN_BIT]) cur_q <= nxt_q;
                else                        cur_q <= cur_q + AW'(DESC_BYTES);
            end
        end
    end

endmodule

// File: rtl/chain_dma_status.sv
module chain_dma_status
    import chain_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            evt_done,
    input  logic            evt_tx,
    input  logic            evt_unavail,
    input  logic [ST_W-1:0] sts_clr,
    output logic [ST_W-1:0] sts,
    output logic            irq
);

    logic [ST_W-1:0] set_v;

    always_comb begin
        set_v          = '0;
        set_v[ST_TX]   = evt_done && evt_tx;
        set_v[ST_RX]   = evt_done && !evt_tx;
        set_v[ST_SUM]  = evt_done;
        set_v[ST_UNAV] = evt_unavail;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) sts <= '0;
        else                    sts <= (sts & ~sts_clr) | set_v;
    end

    assign irq = sts[ST_SUM] | sts[ST_UNAV];

endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          enable,
    input  logic          poll,
    input  logic          dir_tx,
    input  logic [AW-1:0] base_addr,
    input  logic [3:0]    sts_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          fifo_push,
    output logic [31:0]   fifo_wdata,
    input  logic          fifo_full,
    output logic          fifo_pop,
    input  logic [31:0]   fifo_rdata,
    input  logic          fifo_empty,
    output logic          busy,
    output logic [3:0]    sts,
    output logic          irq
);

    logic evt_done, evt_tx, evt_unavail;

    chain_dma_core #(.AW(AW), .LEN_W(LEN_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .enable     (enable),
        .poll       (poll),
        .dir_tx     (dir_tx),
        .base_addr  (base_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .fifo_full  (fifo_full),
        .fifo_pop   (fifo_pop),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (fifo_empty),
        .busy       (busy),
        .evt_done   (evt_done),
        .evt_tx     (evt_tx),
        .evt_unavail(evt_unavail)
    );

    chain_dma_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .evt_done   (evt_done),
        .evt_tx     (evt_tx),
        .evt_unavail(evt_unavail),
        .sts_clr    (sts_clr),
        .sts        (sts),
        .irq        (irq)
    );

endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          enable,
    input logic          poll,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          fifo_push,
    input logic          fifo_full,
    input logic          fifo_pop,
    input logic          fifo_empty,
    input logic [3:0]    sts,
    input logic          irq
);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_no_push_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    assert_no_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_poll_gated_R2: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !busy && poll && !enable |=> !busy);

    assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy && sts == 4'b0000 && !irq);

    assert_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[0]) || $rose(sts[1]) |-> sts[2] && irq);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !fifo_push && !fifo_pop);

endmodule

bind chain_dma chain_dma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .enable    (enable),
    .poll      (poll),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .fifo_push (fifo_push),
    .fifo_full (fifo_full),
    .fifo_pop  (fifo_pop),
    .fifo_empty(fifo_empty),
    .sts       (sts),
    .irq       (irq)
);

// File: tb/tb_chain_dma.sv
module tb_chain_dma;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] F_OWN = 32'h8000_0000;
    localparam logic [31:0] F_EOR = 32'h20;
    localparam logic [31:0] F_CH  = 32'h10;
    localparam logic [31:0] F_FS  = 32'h08;
    localparam logic [31:0] F_LD  = 32'h04;
    localparam logic [31:0] F_DIC = 32'h02;

    logic        clk = 0, rst_n = 0, soft_rst = 0, enable = 1, poll = 0, dir_tx = 1;
    logic [31:0] base_addr = 32'h100;
    logic [3:0]  sts_clr = 0;
    logic        mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        fifo_push, fifo_full = 0, fifo_pop, fifo_empty, stall_e = 0;
    logic [31:0] fifo_wdata, fifo_rdata;
    logic        busy, irq;
    logic [3:0]  sts;

    logic [31:0] mem [0:511];
    logic [31:0] src_mem [0:63];
    int          src_idx = 0, src_cnt = 0;
    logic [31:0] exp_q [$];
    int          n_checks = 0, n_fail = 0, push_cnt = 0, cyc = 0;

    chain_dma dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable), .poll(poll),
        .dir_tx(dir_tx), .base_addr(base_addr), .sts_clr(sts_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .busy(busy), .sts(sts), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model with a stall rhythm, and FIFO flag rhythm
    always @(posedge clk) begin
        cyc <= cyc + 1;
        fifo_full <= (cyc % 8 == 3);
        stall_e   <= (cyc % 8 == 6);
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req && (cyc % 4 != 1)) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:2]];
        end
        if (fifo_pop) src_idx <= src_idx + 1;
    end

    assign fifo_rdata = src_mem[src_idx[5:0]];
    assign fifo_empty = (src_idx >= src_cnt) || stall_e;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for FIFO pushes
    always @(negedge clk) begin
        if (rst_n && fifo_push) begin
            push_cnt++;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected push actual=%h expected=none", fifo_wdata);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (fifo_wdata !== e) begin
                    n_fail++;
                    $display("FAIL R5 push data actual=%h expected=%h", fifo_wdata, e);
                end
            end
        end
    end

    function automatic int wi(input logic [31:0] a);
        return int'(a[10:2]);
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] len,
                            input logic [31:0] b, input logic [31:0] n);
        mem[wi(a)] = c; mem[wi(a+4)] = len; mem[wi(a+8)] = b; mem[wi(a+12)] = n;
    endtask

    task automatic expect_tx(input logic [31:0] b, input int nbytes);
        for (int i = 0; i < (nbytes + 3) / 4; i++) exp_q.push_back(mem[wi(b + 32'(4*i))]);
    endtask

    task automatic add_src(input logic [31:0] v);
        src_mem[src_cnt[5:0]] = v;
        src_cnt++;
    endtask

    task automatic run_poll();
        @(negedge clk) poll = 1;
        @(negedge clk) poll = 0;
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic clear_sts(input logic [3:0] m);
        @(negedge clk) sts_clr = m;
        @(negedge clk) sts_clr = 0;
    endtask

    initial begin
        int pc;
        for (int i = 0; i < 512; i++) mem[i] = 32'hA000_0000 + 32'(i * 7);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset sts", 32'(sts), 0);
        chk("R1 reset irq", 32'(irq), 0);

        // chained then contiguous, transmit, odd length
        put_desc(32'h100, F_OWN | F_FS | F_CH | F_DIC, 10, 32'h400, 32'h200);
        put_desc(32'h200, F_OWN | F_LD, 8, 32'h500, 32'h7F0);
        expect_tx(32'h400, 10);
        expect_tx(32'h500, 8);
        dir_tx = 1;
        pc = push_cnt;
        run_poll();
        chk("R4 word count tx", 32'(push_cnt - pc), 5);
        chk("R5 all words pushed", 32'(exp_q.size()), 0);
        chk("R7 writeback A", mem[wi(32'h100)], F_FS | F_CH | F_DIC);
        chk("R7 writeback B", mem[wi(32'h200)], F_LD);
        chk("R9 stop after last", 32'(busy), 0);
        chk("R10 tx done status", 32'(sts), 32'b0101);
        chk("R10 irq", 32'(irq), 1);
        clear_sts(4'hF);
        chk("R11 clear all", 32'(sts), 0);

        // receive, contiguous step to 0x210, end-of-ring wrap to base
        put_desc(32'h210, F_OWN | F_FS | F_EOR | F_DIC, 4, 32'h600, 32'h7F0);
        put_desc(32'h100, F_OWN | F_LD, 12, 32'h700, 32'h7F0);
        add_src(32'h1111_0001); add_src(32'h2222_0002);
        add_src(32'h3333_0003); add_src(32'h4444_0004);
        dir_tx = 0;
        run_poll();
        chk("R8 contiguous then R6 rx word0", mem[wi(32'h600)], 32'h1111_0001);
        chk("R8 end-of-ring R6 rx word1", mem[wi(32'h700)], 32'h2222_0002);
        chk("R6 rx word2", mem[wi(32'h704)], 32'h3333_0003);
        chk("R6 rx word3", mem[wi(32'h708)], 32'h4444_0004);
        chk("R12 all popped", 32'(src_idx), 32'(src_cnt));
        chk("R7 writeback C", mem[wi(32'h210)], F_FS | F_EOR | F_DIC);
        chk("R10 rx done status", 32'(sts), 32'b0110);
        clear_sts(4'hF);

        // unowned descriptor at 0x110
        put_desc(32'h110, 32'h0, 4, 32'h400, 32'h0);
        dir_tx = 1;
        pc = push_cnt;
        run_poll();
        chk("R3 unavailable status", 32'(sts), 32'b1000);
        chk("R3 irq", 32'(irq), 1);
        chk("R3 no data moved", 32'(push_cnt - pc), 0);
        chk("R3 descriptor untouched", mem[wi(32'h110)], 0);
        // resume on same address, zero-length
        put_desc(32'h110, F_OWN | F_LD, 0, 32'h400, 32'h0);
        run_poll();
        chk("R4 zero length", 32'(push_cnt - pc), 0);
        chk("R3 resumed same address", mem[wi(32'h110)], F_LD);
        chk("R11 set kept", 32'(sts), 32'b1101);
        clear_sts(4'hF);

        // interrupt suppressed, contiguous 0x120
        put_desc(32'h120, F_OWN | F_LD | F_DIC, 4, 32'h404, 32'h0);
        expect_tx(32'h404, 4);
        run_poll();
        chk("R10 suppressed status", 32'(sts), 0);
        chk("R10 suppressed irq", 32'(irq), 0);
        chk("R7 writeback D", mem[wi(32'h120)], F_LD | F_DIC);

        // poll while disabled
        put_desc(32'h130, F_OWN | F_LD, 4, 32'h408, 32'h0);
        pc = push_cnt;
        enable = 0;
        @(negedge clk) poll = 1;
        @(negedge clk) poll = 0;
        repeat (20) @(negedge clk);
        chk("R2 disabled busy", 32'(busy), 0);
        chk("R2 disabled no fetch", mem[wi(32'h130)], F_OWN | F_LD);
        chk("R2 disabled no push", 32'(push_cnt - pc), 0);
        enable = 1;

        // soft reset re-selects base
        @(negedge clk) soft_rst = 1;
        @(negedge clk) soft_rst = 0;
        chk("R1 soft reset busy", 32'(busy), 0);
        chk("R1 soft reset sts", 32'(sts), 0);
        base_addr = 32'h040;
        put_desc(32'h040, F_OWN | F_LD, 8, 32'h500, 32'h0);
        expect_tx(32'h500, 8);
        run_poll();
        chk("R1 fetched from base", mem[wi(32'h040)], F_LD);
        chk("R2 old address untouched", mem[wi(32'h130)], F_OWN | F_LD);
        chk("R5 queue drained", 32'(exp_q.size()), 0);
        chk("R10 tx again", 32'(sts), 32'b0101);
        clear_sts(4'b0001);
        chk("R11 partial clear", 32'(sts), 32'b0100);
        chk("R11 irq held", 32'(irq), 1);
        clear_sts(4'b0100);
        chk("R11 clear summary", 32'(sts), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule